// File: doc/BRIEF.md
# Streaming Network Receive Line Buffer

A small fully associative line buffer that holds incoming network packet data apart from the processor cache hierarchy. A DMA write port appends one data line per cycle at the tail of a circular store, in arrival order. A processor read port looks up a line address against every valid line and answers one cycle later with a hit flag and the line data. On a miss the block only reports the miss; it fetches nothing.

Capacity stays small because lines leave as they are consumed, not when space runs out. The line at the head goes on its second access. A read that hits a line younger than the head drops every older line, and that read counts as the hit line's first access. The valid lines therefore always form one unbroken run from head to tail. When every line is valid, a DMA write is refused and a full flag is shown for that cycle.

Top module: `net_fifo_cache`

## Requirements
- R1: After reset no line is valid, `rd_resp_valid_o` and `rd_hit_o` are low and `wr_full_o` is low.
- R2: A DMA write is accepted in any cycle in which fewer than LINES lines are valid. It stores its address and data at the tail as a fresh line with zero accesses.
- R3: While all LINES lines are valid, `wr_full_o` is high in that same cycle and a DMA write is dropped. No stored line changes because of it.
- R4: A read request gets `rd_resp_valid_o` high exactly one cycle later. On a hit it also gets `rd_hit_o` high and the stored data. When several valid lines share the address, the oldest of them answers.
- R5: A read that misses gives `rd_hit_o` low and `rd_data_o` all zero, and it changes no line and no pointer.
- R6: A line is invalidated by its second hit while it is the oldest valid line. A third read of that address misses, unless a newer line with the same address exists.
- R7: A hit on a line younger than the oldest valid line invalidates every older line. The hit counts as that line's first access.
- R8: A write and a read in the same cycle are both handled. Acceptance of the write depends on the occupancy before the read. A read that frees a slot while the store is full does not admit a write in the same cycle, and a write in the next cycle is accepted.
- R9: A read looks at the state before any same-cycle write, so a read of the address being written in that cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | DMA write request |
| wr_addr_i | input | ADDR_W | Line address of the DMA write |
| wr_data_i | input | DATA_W | Line data of the DMA write |
| wr_full_o | output | 1 | All lines valid; a write in this cycle is refused |
| rd_valid_i | input | 1 | Processor read request |
| rd_addr_i | input | ADDR_W | Line address to look up |
| rd_resp_valid_o | output | 1 | Read answer present (one cycle after the request) |
| rd_hit_o | output | 1 | Read hit |
| rd_data_o | output | DATA_W | Hit data, zero on miss |

## Verification
`wr_full_o` is combinational, so the bench samples it 1 ns after it drives each cycle's inputs, before the edge that would take the write. Each read's answer is due at the next rising edge. The bench records the expected answer in a queue at the moment it drives the request. A monitor pops one entry 2 ns after every rising edge and compares it with `rd_resp_valid_o`, `rd_hit_o` and `rd_data_o`. Idle cycles push entries that expect no answer, so a late or early response shows up as a mismatch.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_MISS = 2'd1,
    RD_KEEP = 2'd2,
    RD_KILL = 2'd3
  } rd_act_e;
endpackage

// File: rtl/nfc_lookup.sv
// Oldest-first associative match: search starts at head and walks toward tail.
module nfc_lookup #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]             valid_i,
  input  logic [LINES-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [PTR_W-1:0]             head_i,
  output logic                         hit_o,
  output logic [PTR_W-1:0]             idx_o,
  output logic [PTR_W-1:0]             dist_o
);
  logic [PTR_W-1:0] slot;

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    dist_o = '0;
    slot   = '0;
    for (int i = 0; i < LINES; i++) begin
      slot = head_i + PTR_W'(i);
      if (!hit_o && valid_i[slot] && tag_i[slot] == addr_i) begin
        hit_o  = 1'b1;
        idx_o  = slot;
        dist_o = PTR_W'(i);
      end
    end
  end
endmodule

// File: rtl/nfc_line_store.sv
module nfc_line_store #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 2,
  localparam int PTR_W = $clog2(LINES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [PTR_W-1:0]             wr_idx_i,
  input  logic [ADDR_W-1:0]            wr_tag_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [LINES-1:0]             clr_i,
  input  logic                         inc_en_i,
  input  logic [PTR_W-1:0]             inc_idx_i,
  output logic [LINES-1:0]             valid_o,
  output logic [LINES-1:0][ADDR_W-1:0] tag_o,
  output logic [LINES-1:0][DATA_W-1:0] data_o,
  output logic [LINES-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        cnt_o[g]   <= '0;
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (wr_en_i && wr_idx_i == PTR_W'(g)) begin
        valid_o[g] <= 1'b1;
        cnt_o[g]   <= '0;
        tag_o[g]   <= wr_tag_i;
        data_o[g]  <= wr_data_i;
      end else if (clr_i[g]) begin
        valid_o[g] <= 1'b0;
        cnt_o[g]   <= '0;
      end else if (inc_en_i && inc_idx_i == PTR_W'(g)) begin
        cnt_o[g]   <= cnt_o[g] + CNT_W'(1);
      end
    end
  end

  // R3: a write never lands on a live line
  a_r3_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !valid_o[wr_idx_i]);
  // R8: same-cycle write and eviction never target one slot
  a_r8_no_slot_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !clr_i[wr_idx_i]);
endmodule

// File: rtl/net_fifo_cache.sv
module net_fifo_cache
  import nfc_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_resp_valid_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  // LINES must be a power of two: pointers wrap by overflow
  localparam int PTR_W = $clog2(LINES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

  logic [PTR_W-1:0]             head_q, tail_q, head_d;
  logic [LINES-1:0]             valid;
  logic [LINES-1:0][ADDR_W-1:0] tags;
  logic [LINES-1:0][DATA_W-1:0] datas;
  logic [LINES-1:0][CNT_W-1:0]  cnts;
  logic [LINES-1:0]             clr;
  logic                         lk_hit;
  logic [PTR_W-1:0]             lk_idx, lk_dist;
  logic                         wr_acc, rd_hit, kill;
  rd_act_e                      rd_act;

  nfc_lookup #(.LINES(LINES), .ADDR_W(ADDR_W)) u_lookup (
    .valid_i (valid),
    .tag_i   (tags),
    .addr_i  (rd_addr_i),
    .head_i  (head_q),
    .hit_o   (lk_hit),
    .idx_o   (lk_idx),
    .dist_o  (lk_dist)
  );

  assign wr_full_o = &valid;
  assign wr_acc    = wr_valid_i && !wr_full_o;
  assign rd_hit    = rd_valid_i && lk_hit;
  assign kill      = rd_hit && cnts[lk_idx] == LAST_CNT;

  always_comb begin
    if (!rd_valid_i)  rd_act = RD_IDLE;
    else if (!lk_hit) rd_act = RD_MISS;
    else if (kill)    rd_act = RD_KILL;
    else              rd_act = RD_KEEP;
  end

  // drop lines older than the hit; drop the hit too on its second access
  for (genvar j = 0; j < LINES; j++) begin : g_clr
    logic [PTR_W-1:0] rel;
    assign rel    = PTR_W'(j) - head_q;
    assign clr[j] = rd_hit && ((rel < lk_dist) || (kill && rel == lk_dist));
  end

  // live lines stay contiguous, so head lands on the next valid line or on tail
  always_comb begin
    unique case (rd_act)
      RD_KILL: head_d = lk_idx + PTR_W'(1);
      RD_KEEP: head_d = lk_idx;
      default: head_d = head_q;
    endcase
  end

  nfc_line_store #(
    .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_acc),
    .wr_idx_i  (tail_q),
    .wr_tag_i  (wr_addr_i),
    .wr_data_i (wr_data_i),
    .clr_i     (clr),
    .inc_en_i  (rd_hit),
    .inc_idx_i (lk_idx),
    .valid_o   (valid),
    .tag_o     (tags),
    .data_o    (datas),
    .cnt_o     (cnts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q          <= '0;
      tail_q          <= '0;
      rd_resp_valid_o <= 1'b0;
      rd_hit_o        <= 1'b0;
      rd_data_o       <= '0;
    end else begin
      head_q          <= head_d;
      if (wr_acc) tail_q <= tail_q + PTR_W'(1);
      rd_resp_valid_o <= rd_valid_i;
      rd_hit_o        <= rd_hit;
      rd_data_o       <= rd_hit ? datas[lk_idx] : '0;
    end
  end

  a_r4_resp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_resp_valid_o);
  a_r4_no_stray_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rd_resp_valid_o);
  a_r4_hit_has_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_resp_valid_o);
  a_r5_miss_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !lk_hit && !wr_valid_i) |=> ($stable(valid) && $stable(head_q)));
  a_r3_full_holds_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_full_o) |=> $stable(tail_q));
  a_r7_head_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid) |-> valid[head_q]);
endmodule

// File: tb/net_fifo_cache_bench.sv
`timescale 1ns/1ps
module net_fifo_cache_bench;
  localparam int LINES  = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    int                c;
  } line_t;

  typedef struct {
    bit                rv;
    bit                hit;
    logic [DATA_W-1:0] d;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_full;
  logic              rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_resp_valid, rd_hit;
  logic [DATA_W-1:0] rd_data;

  int    checks = 0;
  int    fails  = 0;
  int    seq    = 0;
  bit    done   = 1'b0;
  line_t mdl[$];
  exp_t  expq[$];

  always #4 clk = ~clk;  // 125 MHz

  net_fifo_cache #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_net_fifo_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_full_o(wr_full),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .rd_resp_valid_o(rd_resp_valid), .rd_hit_o(rd_hit), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus; model updated in order read-then-write on pre-state
  task automatic cyc(input bit wv, input logic [ADDR_W-1:0] wa,
                     input bit rv, input logic [ADDR_W-1:0] ra, input string tag);
    exp_t e;
    bit   full_pre;
    int   f;
    line_t ln;
    @(negedge clk);
    seq++;
    wr_valid = wv; wr_addr = wa; wr_data = {32'(seq), wa};
    rd_valid = rv; rd_addr = ra;
    #1;
    full_pre = (mdl.size() == LINES);
    chk(wr_full == full_pre, tag, "wr_full", DATA_W'(wr_full), DATA_W'(full_pre));
    e.rv = rv; e.hit = 1'b0; e.d = '0; e.tag = tag;
    if (rv) begin
      f = -1;
      for (int i = 0; i < mdl.size(); i++)
        if (f < 0 && mdl[i].a == ra) f = i;
      if (f >= 0) begin
        e.hit = 1'b1;
        e.d   = mdl[f].d;
        for (int i = 0; i < f; i++) void'(mdl.pop_front());
        mdl[0].c++;
        if (mdl[0].c == 2) void'(mdl.pop_front());
      end
    end
    if (wv && !full_pre) begin
      ln.a = wa; ln.d = {32'(seq), wa}; ln.c = 0;
      mdl.push_back(ln);
    end
    expq.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, "idle");
  endtask

  // monitor: answer for the request driven before this edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      chk(rd_resp_valid == e.rv, e.tag, "rd_resp_valid",
          DATA_W'(rd_resp_valid), DATA_W'(e.rv));
      if (e.rv) begin
        chk(rd_hit == e.hit, e.tag, "rd_hit", DATA_W'(rd_hit), DATA_W'(e.hit));
        chk(rd_data == e.d, e.tag, "rd_data", rd_data, e.d);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rd_resp_valid == 1'b0, "R1", "rd_resp_valid", DATA_W'(rd_resp_valid), '0);
    chk(rd_hit == 1'b0, "R1", "rd_hit", DATA_W'(rd_hit), '0);
    chk(wr_full == 1'b0, "R1", "wr_full", DATA_W'(wr_full), '0);
    rst_n = 1'b1;
    idle(2);

    // R2, R6, R7
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'hA0 + 32'(i), 1'b0, '0, "R2");
    cyc(1'b0, '0, 1'b1, 32'hA0, "R6");
    cyc(1'b0, '0, 1'b1, 32'hA0, "R6");
    cyc(1'b0, '0, 1'b1, 32'hA0, "R6");
    cyc(1'b0, '0, 1'b1, 32'hA1, "R4");
    cyc(1'b0, '0, 1'b1, 32'hA3, "R7");
    cyc(1'b0, '0, 1'b1, 32'hA2, "R7");
    cyc(1'b0, '0, 1'b1, 32'hA1, "R7");
    cyc(1'b0, '0, 1'b1, 32'hA3, "R6");
    idle(1);

    // R3, R8: fill, refuse, slot freed while full
    for (int i = 0; i < LINES; i++) cyc(1'b1, 32'h100 + 32'(i), 1'b0, '0, "R2");
    cyc(1'b1, 32'h1FF, 1'b0, '0, "R3");
    cyc(1'b0, '0, 1'b1, 32'h100, "R3");
    cyc(1'b0, '0, 1'b1, 32'h1FF, "R3");
    cyc(1'b1, 32'h200, 1'b1, 32'h100, "R8");
    cyc(1'b1, 32'h201, 1'b0, '0, "R8");
    cyc(1'b0, '0, 1'b1, 32'h200, "R8");
    cyc(1'b0, '0, 1'b1, 32'h201, "R7");
    cyc(1'b0, '0, 1'b1, 32'h101, "R7");
    cyc(1'b0, '0, 1'b1, 32'h201, "R6");

    // R9: same-cycle write and read of one address
    cyc(1'b1, 32'h300, 1'b1, 32'h300, "R9");
    cyc(1'b0, '0, 1'b1, 32'h300, "R9");
    // R5: miss leaves state alone
    cyc(1'b0, '0, 1'b1, 32'hDEAD, "R5");
    cyc(1'b0, '0, 1'b1, 32'h300, "R5");
    cyc(1'b0, '0, 1'b1, 32'h300, "R5");

    // R4: duplicate addresses, oldest answers
    cyc(1'b1, 32'h400, 1'b0, '0, "R4");
    cyc(1'b1, 32'h400, 1'b0, '0, "R4");
    cyc(1'b0, '0, 1'b1, 32'h400, "R4");
    cyc(1'b0, '0, 1'b1, 32'h400, "R4");
    cyc(1'b0, '0, 1'b1, 32'h400, "R6");
    cyc(1'b0, '0, 1'b1, 32'h400, "R6");

    // R8 mixed traffic, small address set
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], 32'h500 + 32'(lfsr[4:2]),
          lfsr[5] & ~lfsr[8], 32'h500 + 32'(lfsr[11:9]), "R8");
    end
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule